// File: doc/BRIEF.md
# Branch Direction Predictor Table

This block predicts whether a conditional branch will be taken. It is a direct-mapped table of small counters, and it is looked up in the fetch stage. A branch's entry is chosen by low-order bits of its instruction address. The two lowest address bits are dropped first, because word-aligned instructions always have zeros there. The table holds no targets, tags or global history. Two branches whose addresses share the index bits therefore share one counter, and that aliasing is accepted.

The lookup port is purely combinational. It takes the fetch address and gives a direction in the same cycle. The update port takes the address of a branch that has just resolved, its real outcome and a valid strobe. It adjusts the addressed entry at the next clock edge. A parameter chooses the scheme. In last-outcome mode each entry is a single bit that simply remembers the most recent result. In counter mode each entry is an N-bit saturating counter. Leaving a strong state then takes two consecutive mispredictions, which helps with loop branches.

Top module: `bht_predictor`

## Requirements
- R1: After reset every entry predicts taken. In counter mode every counter starts at its maximum value, all ones (strongly taken).
- R2: The entry index is PC bits [IDX_W+1:2], where IDX_W = log2(DEPTH). With DEPTH=64 the index is PC[7:2]. PC bits 1:0 and all bits above the index have no effect on which entry is selected.
- R3: `lk_taken` is a combinational function of `lk_pc` and the table contents, valid in the same cycle that `lk_pc` is applied.
- R4: While `up_valid` is low, no entry changes, whatever `up_pc` and `up_taken` carry.
- R5: In last-outcome mode (MODE=BHT_LAST, encoding 0), each valid update overwrites the entry's bit with `up_taken`. The prediction equals the last resolved outcome for that index.
- R6: In counter mode (MODE=BHT_SAT, encoding 1), a valid taken update adds one to the entry and a valid not-taken update subtracts one.
- R7: Counters saturate. A taken update at the maximum leaves it at the maximum, and a not-taken update at zero leaves it at zero.
- R8: In counter mode the prediction is taken exactly when the counter is at least 2^(CTR_BITS-1), which is its most significant bit. From the strongly taken state, two not-taken updates in a row are needed before the prediction flips.
- R9: When an update and a lookup address the same entry in the same cycle, the lookup returns the value held before the update. The new value is visible from the following cycle.
- R10: An update changes only the entry its index selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction for `lk_pc` (1 = taken) |
| up_valid | input | 1 | Resolved branch update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
A lookup and an update can land on the same entry in the same cycle. This is the case the design must order correctly. The bench provokes it by driving `up_pc` and `lk_pc` to the same address together with `up_valid`. It then judges `lk_taken` twice. The first sample is taken just after the driving edge and must show the pre-update direction. The second is taken one clock later and must show the updated direction. The bench does this in both modes, and in counter mode it starts from a state where one step changes nothing visible and a second step flips the prediction.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef enum logic {
    BHT_LAST = 1'b0,
    BHT_SAT  = 1'b1
  } bht_mode_e;
endpackage

// File: rtl/bht_rst_sync.sv
module bht_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bht_index.sv
module bht_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  localparam int LO = 2;
  localparam int HI = IDX_W + LO - 1;

  assign idx = pc[HI:LO];
endmodule

// File: rtl/bht_entry.sv
module bht_entry #(
  parameter int W       = 2,
  parameter bit ONE_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic         upd_taken,
  output logic [W-1:0] ctr
);
  localparam logic [W-1:0] CTR_MAX = '1;
  localparam logic [W-1:0] CTR_MIN = '0;
  localparam logic [W-1:0] CTR_ONE = W'(1);

  logic [W-1:0] ctr_d;

  always_comb begin
    ctr_d = ctr;
    if (ONE_BIT) begin
      ctr_d = {W{upd_taken}};
    end else if (upd_taken) begin
      if (ctr != CTR_MAX) ctr_d = ctr + CTR_ONE;
    end else begin
      if (ctr != CTR_MIN) ctr_d = ctr - CTR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr <= CTR_MAX;
    end else if (upd_en) begin
      ctr <= ctr_d;
    end
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(ctr));

  // R7
  top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_taken && ctr == CTR_MAX) |=> ctr == CTR_MAX);

  // R7
  bot_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken && ctr == CTR_MIN) |=> ctr == CTR_MIN);

  generate
    if (ONE_BIT) begin : g_last_chk
      // R5
      last_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> ctr[0] == $past(upd_taken));
    end else begin : g_sat_chk
      // R6
      step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && ctr != CTR_MAX) |=> ctr == $past(ctr) + CTR_ONE);
      // R6
      step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken && ctr != CTR_MIN) |=> ctr == $past(ctr) - CTR_ONE);
    end
  endgenerate
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor #(
  parameter int                PC_W     = 32,
  parameter int                DEPTH    = 64,
  parameter int                CTR_BITS = 2,
  parameter bht_pkg::bht_mode_e MODE    = bht_pkg::BHT_SAT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int IDX_W   = $clog2(DEPTH);
  localparam bit ONE_BIT = (MODE == bht_pkg::BHT_LAST);
  localparam int W       = ONE_BIT ? 1 : CTR_BITS;

  logic             rst_sync_n;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  logic [W-1:0]     ctr_arr [DEPTH];
  logic [W-1:0]     lk_ctr;

  bht_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_idx (
    .pc  (lk_pc),
    .idx (lk_idx)
  );

  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_idx (
    .pc  (up_pc),
    .idx (up_idx)
  );

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      logic sel_en;
      assign sel_en = up_valid && (up_idx == IDX_W'(i));
      bht_entry #(.W(W), .ONE_BIT(ONE_BIT)) u_ent (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .upd_en    (sel_en),
        .upd_taken (up_taken),
        .ctr       (ctr_arr[i])
      );
    end
  endgenerate

  always_comb begin
    lk_ctr   = ctr_arr[lk_idx];
    lk_taken = lk_ctr[W-1];
  end
endmodule

// File: tb/sim_bht_predictor.sv
module sim_bht_predictor;
  localparam int PC_W = 32;
  localparam int MAXCYC = 200000;

  logic            clk;
  logic            rst_n;
  logic [PC_W-1:0] lk_pc;
  logic            up_valid;
  logic [PC_W-1:0] up_pc;
  logic            up_taken;
  logic            t_sat;
  logic            t_last;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bht_predictor #(.PC_W(PC_W), .DEPTH(64), .CTR_BITS(2), .MODE(bht_pkg::BHT_SAT)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(t_sat),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  bht_predictor #(.PC_W(PC_W), .DEPTH(64), .CTR_BITS(2), .MODE(bht_pkg::BHT_LAST)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(t_last),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc);
    lk_pc = pc;
    #1;
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic t);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_taken = t;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    look(32'h0000_0000); chk("R1 sat", t_sat, 1'b1); chk("R1 last", t_last, 1'b1);
    look(32'h0000_00FC); chk("R1 sat hi", t_sat, 1'b1); chk("R1 last hi", t_last, 1'b1);
    look(32'h8000_0044); chk("R3 lookup", t_sat, 1'b1);
  endtask

  task automatic t_counter;
    logic [PC_W-1:0] a = 32'h0000_0040;
    upd(a, 1'b0); look(a);
    chk("R8 one miss stays taken", t_sat, 1'b1); chk("R5 last follows NT", t_last, 1'b0);
    upd(a, 1'b0); look(a); chk("R8 two misses flip", t_sat, 1'b0);
    upd(a, 1'b0); upd(a, 1'b1); look(a);
    chk("R7 floor then one taken", t_sat, 1'b0); chk("R5 last follows T", t_last, 1'b1);
    upd(a, 1'b1); look(a); chk("R6 count up to weak taken", t_sat, 1'b1);
    upd(a, 1'b1); upd(a, 1'b1); upd(a, 1'b1); upd(a, 1'b0); look(a);
    chk("R7 ceiling holds", t_sat, 1'b1);
  endtask

  task automatic t_alias;
    upd(32'h0000_0104, 1'b0); upd(32'h0000_0104, 1'b0);
    look(32'h1000_0107); chk("R2 alias sat", t_sat, 1'b0); chk("R2 alias last", t_last, 1'b0);
    look(32'h0000_0204); chk("R2 upper bits ignored", t_sat, 1'b0);
    look(32'h0000_0108); chk("R10 neighbour sat", t_sat, 1'b1); chk("R10 neighbour last", t_last, 1'b1);
  endtask

  task automatic t_gate;
    @(negedge clk);
    up_valid = 1'b0; up_pc = 32'h0000_0180; up_taken = 1'b0;
    repeat (5) @(negedge clk);
    look(32'h0000_0180);
    chk("R4 gated sat", t_sat, 1'b1); chk("R4 gated last", t_last, 1'b1);
  endtask

  task automatic t_same_cycle;
    logic [PC_W-1:0] b = 32'h0000_02C0;
    @(negedge clk);
    up_valid = 1'b1; up_pc = b; up_taken = 1'b0; look(b);
    chk("R9 last old value", t_last, 1'b1); chk("R9 sat old value", t_sat, 1'b1);
    @(negedge clk);
    #1; chk("R9 last new value", t_last, 1'b0); chk("R9 sat after one", t_sat, 1'b1);
    chk("R9 sat old value again", t_sat, 1'b1);
    @(negedge clk);
    up_valid = 1'b0; #1;
    chk("R8 sat after two", t_sat, 1'b0);
  endtask

  task automatic t_loop;
    logic [PC_W-1:0] c = 32'h0000_0300;
    int miss_s = 0;
    int miss_l = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 10; i++) begin
        logic o = (i < 9);
        @(negedge clk);
        look(c);
        if (pass == 1) begin
          if (t_sat != o) miss_s++;
          if (t_last != o) miss_l++;
        end
        upd(c, o);
      end
    end
    checks++;
    if (miss_s != 1) begin errors++; $display("FAIL R8 loop misses got %0d expected 1", miss_s); end
    checks++;
    if (miss_l != 2) begin errors++; $display("FAIL R5 loop misses got %0d expected 2", miss_l); end
  endtask

  initial begin
    rst_n = 1'b0; lk_pc = '0; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_counter;
    t_alias;
    t_gate;
    t_same_cycle;
    t_loop;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAXCYC) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule